// File: doc/BRIEF.md
# Output Rounding, Limiting and Format Stage

This stage sits at the tail of a fixed-coefficient filter datapath. It takes the wide signed filter result, rounds it to an output width of 8 to 16 bits, clamps it so that it never wraps, and recodes it as two's complement, offset binary or inverted offset binary. The 16-bit bus is left-justified: the kept bits sit at the top, and every bit below the selected width is released. A per-bit drive-enable mask tells the pad logic which bits to drive. An active-low output enable turns the whole mask off without waiting for a clock.

The filter result `fir_res` is a fixed-point number with `FRAC` fraction bits below the 16-bit output LSB. Any headroom above the 16-bit range must be removed by saturation. At unity gain, the top 12 output bits line up with a 12-bit input word.

Top module: `out_round_limit`

## Requirements
- R1: `rnd_sel` picks the kept width K. Code 0 gives 16 bits. Codes 1, 2 and 3 give 15, 14 and 13 bits. Code 4 gives 12 bits when `narrow8`=0 and 8 bits when `narrow8`=1. Codes 5, 6 and 7 give 11, 10 and 9 bits. The kept bits occupy `dout[15:16-K]`.
- R2: `dout` bits below position 16-K are 0. The matching `dout_en` bits are 0, and `dout_en[15:16-K]` are 1 while `oe_n`=0.
- R3: Rounding adds half of the new LSB and then floors. An exact half therefore rounds toward positive infinity.
- R4: A rounded value outside the signed K-bit range is clamped to the largest or smallest K-bit code and never wraps.
- R5: With `half_gain`=1, the clamp range is the signed (K-1)-bit range. On the 16-bit grid this is -16384 to 16383.
- R6: With `clip_video`=1, the clamp levels are 16 and 235 (unsigned) scaled by 2^(K-8). As signed values these are -112 and 107 scaled by 2^(K-8), which is -28672 and 27392 on the 16-bit grid. `half_gain` takes precedence when both are set.
- R7: With `tc_fmt`=1, `dout` is two's complement. With `tc_fmt`=0, `dout` is offset binary (bit 15 of the two's-complement word inverted) with all kept bits then complemented. The exception is that when `uns_io`=1 and `rnd_sel`≠0, `dout` is plain offset binary (unsigned).
- R8: When `uns_io`=1 and `rnd_sel`≠0, `fir_res` is read as unsigned with midscale 2^(FRAC+15). Otherwise it is read as two's complement.
- R9: `oe_n`=1 forces `dout_en` to all zeros at once, with no clock edge. Releasing `oe_n` restores the mask at once.
- R10: `dout` has one register of latency from the data and control inputs. It is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fir_res | input | IN_W | Filter result, FRAC fraction bits |
| rnd_sel | input | 3 | Width code |
| narrow8 | input | 1 | Picks 8 bits for width code 4 |
| tc_fmt | input | 1 | 1 = two's complement output |
| uns_io | input | 1 | Unsigned input/output flag |
| clip_video | input | 1 | Clamp to video levels |
| half_gain | input | 1 | Clamp to 15-bit range |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | 16 | Output word, left-justified |
| dout_en | output | 16 | Per-bit drive enable |

## Verification
The no-wrap assertions assume that `fir_res` is interpreted in two's complement, so they are gated off whenever the unsigned mode is active. The clip-level assertion assumes that the two's-complement output format is selected. The stimulus changes inputs only at falling edges. It sweeps all width codes, format and clamp options, including full-scale and exact-half inputs. A bench model written with integers predicts every cycle's output.

// File: rtl/out_round_limit.sv
module out_round_limit #(
  parameter int FRAC = 2,
  parameter int IN_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] fir_res,
  input  logic [2:0]      rnd_sel,
  input  logic            narrow8,
  input  logic            tc_fmt,
  input  logic            uns_io,
  input  logic            clip_video,
  input  logic            half_gain,
  input  logic            oe_n,
  output logic [15:0]     dout,
  output logic [15:0]     dout_en
);
  localparam int OW = 16;
  localparam int W  = IN_W + 2;
  localparam logic signed [W-1:0] ONE = W'(1);

  logic uns_act;
  logic [15:0] keep, word;
  logic signed [W-1:0] vs, sum, q, hi, lo, sv;
  int k, d, sh;

  assign uns_act = uns_io & (|rnd_sel);

  always_comb begin
    case (rnd_sel)
      3'd0: k = 16;
      3'd1: k = 15;
      3'd2: k = 14;
      3'd3: k = 13;
      3'd4: k = narrow8 ? 8 : 12;
      3'd5: k = 11;
      3'd6: k = 10;
      default: k = 9;
    endcase
    d  = OW - k;
    sh = FRAC + d;
    keep = 16'hFFFF << d;

    if (uns_act) vs = $signed({2'b00, fir_res}) - (ONE <<< (FRAC + OW - 1));
    else         vs = $signed({{2{fir_res[IN_W-1]}}, fir_res});

    sum = vs + (ONE <<< (sh - 1));
    q   = sum >>> sh;

    if (half_gain) begin
      hi = (ONE <<< (k - 2)) - ONE;
      lo = -(ONE <<< (k - 2));
    end else if (clip_video) begin
      hi = W'(107) <<< (k - 8);
      lo = -(W'(112) <<< (k - 8));
    end else begin
      hi = (ONE <<< (k - 1)) - ONE;
      lo = -(ONE <<< (k - 1));
    end

    if (q > hi)      sv = hi;
    else if (q < lo) sv = lo;
    else             sv = q;

    word = 16'(sv <<< d);
    if (!tc_fmt) begin
      word[15] = ~word[15];
      if (!uns_act) word = word ^ keep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dout <= '0;
    else        dout <= word;
  end

  assign dout_en = oe_n ? 16'h0000 : keep;

  assert_released_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dout & ~$past(keep)) == 16'h0000));

  assert_no_wrap_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_fmt && !uns_act && !fir_res[IN_W-1]) |=> !dout[15]);

  assert_no_wrap_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_fmt && !uns_act && fir_res[IN_W-1]) |=> (dout[15] || dout == 16'h0000));

  assert_clip_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clip_video && tc_fmt) |=> ($signed(dout) <= 16'sd27392 && $signed(dout) >= -16'sd28672));

  assert_min_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> ($countones(dout_en) >= 8 && dout_en[15]));

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dout_en == 16'h0000));
endmodule

// File: tb/test_out_round_limit.sv
`timescale 1ns/1ps
module test_out_round_limit;
  logic clk = 0, rst_n = 0;
  logic [19:0] fir_res = 0;
  logic [2:0] rnd_sel = 0;
  logic narrow8 = 0, tc_fmt = 1, uns_io = 0, clip_video = 0, half_gain = 0, oe_n = 0;
  logic [15:0] dout, dout_en;
  int errors = 0, checks = 0;
  logic [15:0] exp_d = 0, exp_en = 16'hFFFF;
  string exp_tag = "R10";

  always #2.5 clk = ~clk;

  out_round_limit i_out_round_limit (.clk, .rst_n, .fir_res, .rnd_sel, .narrow8, .tc_fmt,
    .uns_io, .clip_video, .half_gain, .oe_n, .dout, .dout_en);

  function automatic int width_of(input logic [2:0] r, input logic n8);
    int t[8] = '{16, 15, 14, 13, 12, 11, 10, 9};
    if (r == 3'd4 && n8) return 8;
    return t[r];
  endfunction

  function automatic logic [15:0] model(input logic [19:0] r, input logic [2:0] rs,
      input logic n8, tc, un, cl, hg);
    int kk = width_of(rs, n8);
    int dd = 16 - kk;
    int s  = 2 + dd;
    bit ua = un && rs != 0;
    longint v, q, hi, lo, km;
    logic [15:0] w;
    v = ua ? longint'(r) - 131072 : longint'($signed(r));
    q = (v + (longint'(1) <<< (s - 1))) >>> s;
    hi = (longint'(1) <<< (kk - 1)) - 1;
    lo = -(longint'(1) <<< (kk - 1));
    if (cl) begin
      if (hi > 107 * (longint'(1) <<< (kk - 8))) hi = 107 * (longint'(1) <<< (kk - 8));
      if (lo < -112 * (longint'(1) <<< (kk - 8))) lo = -112 * (longint'(1) <<< (kk - 8));
    end
    if (hg) begin
      if (hi > (longint'(1) <<< (kk - 2)) - 1) hi = (longint'(1) <<< (kk - 2)) - 1;
      if (lo < -(longint'(1) <<< (kk - 2))) lo = -(longint'(1) <<< (kk - 2));
    end
    if (q > hi) q = hi;
    if (q < lo) q = lo;
    km = (longint'(1) <<< kk) - 1;
    w = 16'((q & km) * (longint'(1) <<< dd));
    if (!tc) begin
      w = w ^ 16'h8000;
      if (!ua) w = w ^ 16'(km * (longint'(1) <<< dd));
    end
    return w;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(input logic [19:0] r, input logic [2:0] rs, input logic n8, tc, un,
      cl, hg, oe, input string tag);
    int kk;
    @(negedge clk);
    check(dout, exp_d, exp_tag);
    check(dout_en, exp_en, "R2");
    fir_res = r; rnd_sel = rs; narrow8 = n8; tc_fmt = tc; uns_io = un;
    clip_video = cl; half_gain = hg; oe_n = oe;
    kk = width_of(rs, n8);
    exp_d = model(r, rs, n8, tc, un, cl, hg);
    exp_en = oe ? 16'h0 : (16'hFFFF << (16 - kk));
    exp_tag = tag;
    #1 check(dout_en, exp_en, "R9");
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 16'h0000, "R10 reset");
    rst_n = 1;
    step(20'd4000, 0, 0, 1, 0, 0, 0, 0, "R10 R1");
    step(20'h7FFFF, 0, 0, 1, 0, 0, 0, 0, "R4");
    step(20'h80000, 0, 0, 1, 0, 0, 0, 0, "R4");
    step(20'd4, 1, 0, 1, 0, 0, 0, 0, "R3");
    step(20'd3, 1, 0, 1, 0, 0, 0, 0, "R3");
    step(-20'sd4, 1, 0, 1, 0, 0, 0, 0, "R3");
    step(-20'sd5, 1, 0, 1, 0, 0, 0, 0, "R3");
    for (int c = 0; c < 8; c++) begin
      step(20'h12345, 3'(c), 0, 1, 0, 0, 0, 0, "R1");
      step(20'h7FFFF, 3'(c), 1, 1, 0, 0, 0, 0, "R4");
      step(20'h80000, 3'(c), 1, 1, 0, 0, 0, 0, "R4");
      step(20'hF1357, 3'(c), 1, 0, 0, 0, 0, 0, "R7");
    end
    step(20'h7FFFF, 0, 0, 1, 0, 0, 1, 0, "R5");
    step(20'h80000, 3, 0, 1, 0, 0, 1, 0, "R5");
    step(20'h7FFFF, 0, 0, 1, 0, 1, 0, 0, "R6");
    step(20'h80000, 0, 0, 1, 0, 1, 0, 0, "R6");
    step(20'h7FFFF, 4, 1, 0, 1, 1, 0, 0, "R6");
    step(20'h0, 4, 1, 0, 1, 1, 0, 0, "R6");
    step(20'h7FFFF, 0, 0, 1, 0, 1, 1, 0, "R6");
    step(20'd131072, 0, 0, 1, 1, 0, 0, 0, "R8");
    step(20'd131072, 2, 0, 1, 1, 0, 0, 0, "R8");
    step(20'd131072, 2, 0, 0, 1, 0, 0, 0, "R7");
    step(20'd140000, 5, 0, 0, 1, 0, 0, 0, "R8");
    step(20'd1000, 6, 0, 0, 0, 0, 0, 0, "R7");
    step(20'd1000, 6, 0, 0, 0, 0, 0, 1, "R9");
    step(20'd2000, 2, 0, 1, 0, 0, 0, 1, "R9");
    step(20'd2000, 2, 0, 1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [19:0] r = 20'($urandom);
      if (i % 3 == 0) r = 20'($signed(20'($urandom)) >>> 4);
      step(r, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom % 4 == 0), "R7 random");
    end
    @(negedge clk);
    check(dout, exp_d, exp_tag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule